// File: doc/BRIEF.md
# Critical-Half-First Line Return

The block sits between a memory data path and a requester. It hands back one 64-byte cache line per request. A request carries a byte address and a flag that marks it as a 32-byte access or a full 64-byte line access. Memory always delivers the whole line as a burst of eight 8-byte beats. The block captures those beats and replays them on a response interface with valid, ready and last flags. The byte address of each beat is sent with it.

For a full-line request, or for a 32-byte request that targets the lower half of the line, the beats go out in ascending order. For a 32-byte request that targets the upper half, the four upper beats go out first and the four lower beats follow. The requester therefore always sees the half it asked for before the rest of the line. A beat is offered as soon as it has been captured and every earlier output beat has gone out, so the unswapped order starts one cycle after the first memory beat. Only one request is in flight at a time.

Top module: `crl_line_return`

## Requirements
- R1: While reset is low, and in the first cycle after it is released, req_ready is 1, rsp_valid is 0 and rsp_last is 0.
- R2: Each accepted request yields exactly eight response handshakes. rsp_last is 1 on the eighth one only, and rsp_valid is 0 in the cycle that follows it.
- R3: When req_half_line is 0, the beats leave in line order 0,1,...,7 whatever the value of address bit 5. Output k carries the k-th memory beat and rsp_addr = {req_addr[31:6], k[2:0], 3'b000}.
- R4: When req_half_line is 1 and req_addr[5] is 0, the order is the same as in R3.
- R5: When req_half_line is 1 and req_addr[5] is 1, the beats leave as line beats 4,5,6,7,0,1,2,3. Each beat keeps its own data and rsp_addr.
- R6: req_ready is 0 from the cycle after acceptance until the last beat's handshake, and returns to 1 in the next cycle. req_valid is ignored meanwhile.
- R7: If rsp_valid is 1 and rsp_ready is 0, then in the next cycle rsp_valid is still 1 and rsp_data, rsp_addr and rsp_last are unchanged.
- R8: mem_valid is ignored while no request is open, and after eight beats of the open request have been captured. Beats are captured in line order (interleave order starting at column 0).
- R9: In the cycle after acceptance, rsp_valid is 0. A beat is offered only once its memory beat has been captured, so in the swapped order of R5 rsp_valid stays 0 until five memory beats have arrived. In the line order it rises the cycle after the first one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block is idle and takes a request |
| req_addr | input | ADDR_W (32) | Byte address of the request |
| req_half_line | input | 1 | 1 = 32-byte access, 0 = full-line access |
| mem_valid | input | 1 | A memory beat is present this cycle |
| mem_data | input | DATA_W (64) | Memory beat data |
| rsp_valid | output | 1 | A response beat is offered |
| rsp_ready | input | 1 | Requester takes the offered beat |
| rsp_data | output | DATA_W (64) | Response beat data |
| rsp_addr | output | ADDR_W (32) | Byte address of the offered beat |
| rsp_last | output | 1 | Offered beat is the eighth of the line |

## Verification
The assertions assume that memory sends its eight beats only after the request has been accepted, in line order and with no backpressure. They also assume that requests are made only while req_ready is high. The bench keeps to this: it drives every burst strictly after the acceptance edge, with pauses of several cycles in some tests. The only stray memory beats it sends go while the block is idle, or after all eight beats have been captured, so they test R8 without breaking the assumptions. A held-up request is raised only to check that the block ignores it, and it is withdrawn before the block becomes idle again.

// File: rtl/crl_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the critical-half-first line return block.
// Assumes nothing beyond the consumers using these names consistently.
package crl_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BUSY = 1'b1
    } crl_state_e;
endpackage

// File: rtl/crl_line_store.sv
`timescale 1ns/1ps
// Module: crl_line_store
// Captures the beats of one line in arrival order and serves random reads.
// A read slot is reported ready once the beat for that slot has been written.
// Assumes beats arrive in line order; writes past a full line are dropped.
module crl_line_store #(
    parameter int DATA_W = 64,
    parameter int BEATS  = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       clear,
    input  logic                       wr_valid,
    input  logic [DATA_W-1:0]          wr_data,
    input  logic [$clog2(BEATS)-1:0]   rd_idx,
    output logic [DATA_W-1:0]          rd_data,
    output logic                       rd_ready
);
    localparam int IDX_W = $clog2(BEATS);
    localparam int CNT_W = IDX_W + 1;

    logic [CNT_W-1:0]  wr_cnt;
    logic [DATA_W-1:0] slot_q [BEATS];
    logic              full;
    logic              wr_en;

    assign full  = (wr_cnt == CNT_W'(BEATS));
    assign wr_en = wr_valid && !full;

    // Fill counter: cleared at a new request, advanced per captured beat.
    always_ff @(posedge clk) begin
        if (!rst_n)      wr_cnt <= '0;
        else if (clear)  wr_cnt <= '0;
        else if (wr_en)  wr_cnt <= wr_cnt + CNT_W'(1);
    end

    // Beat storage: the next free slot takes the incoming beat.
    always_ff @(posedge clk) begin
        if (wr_en) slot_q[wr_cnt[IDX_W-1:0]] <= wr_data;
    end

    assign rd_data  = slot_q[rd_idx];
    assign rd_ready = ({1'b0, rd_idx} < wr_cnt);

    AST_CLEAR_EMPTY: assert property (@(posedge clk) disable iff (!rst_n) clear |=> (wr_cnt == '0)) else $error("store not emptied"); // R8
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n) full |=> (wr_cnt <= CNT_W'(BEATS))) else $error("store overfilled"); // R8
endmodule

// File: rtl/crl_beat_sequencer.sv
`timescale 1ns/1ps
// Module: crl_beat_sequencer
// Counts output beats and maps each one to a line slot. When swap is taken at
// start, the top index bit is flipped so the upper half leaves first.
// Assumes BEATS is a power of two, at least 2.
module crl_beat_sequencer #(
    parameter int BEATS = 8
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start,
    input  logic                       swap_in,
    input  logic                       advance,
    output logic [$clog2(BEATS)-1:0]   slot_idx,
    output logic                       is_last
);
    localparam int IDX_W = $clog2(BEATS);
    localparam logic [IDX_W-1:0] HALF_MASK = IDX_W'(BEATS / 2);

    logic [IDX_W-1:0] out_cnt;
    logic             swap_q;

    // Output counter and swap choice, both latched at request start.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_cnt <= '0;
            swap_q  <= 1'b0;
        end else if (start) begin
            out_cnt <= '0;
            swap_q  <= swap_in;
        end else if (advance) begin
            out_cnt <= out_cnt + IDX_W'(1);
        end
    end

    assign slot_idx = out_cnt ^ (swap_q ? HALF_MASK : '0);
    assign is_last  = (out_cnt == IDX_W'(BEATS - 1));

    AST_SWAP_HELD: assert property (@(posedge clk) disable iff (!rst_n) !start |=> $stable(swap_q)) else $error("swap changed mid-line"); // R5
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n) (advance && !start) |=> (out_cnt == $past(out_cnt) + IDX_W'(1))) else $error("beat count skipped"); // R2
endmodule

// File: rtl/crl_line_return.sv
`timescale 1ns/1ps
// Module: crl_line_return (top)
// Accepts one line request at a time, captures the eight-beat memory burst,
// and replays it with the addressed half first for 32-byte requests.
// Assumes memory beats come only after acceptance, in line order, unstalled.
module crl_line_return
    import crl_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 64,
    parameter int BEATS  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_half_line,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic [DATA_W-1:0] rsp_data,
    output logic [ADDR_W-1:0] rsp_addr,
    output logic              rsp_last
);
    localparam int BEAT_BYTES = DATA_W / 8;
    localparam int BEAT_OFF   = $clog2(BEAT_BYTES);
    localparam int IDX_W      = $clog2(BEATS);
    localparam int OFF_W      = IDX_W + BEAT_OFF;
    localparam int HALF_BIT   = OFF_W - 1;
    localparam int LINE_W     = ADDR_W - OFF_W;

    crl_state_e        state;
    logic [LINE_W-1:0] line_q;
    logic              accept;
    logic              busy;
    logic              swap;
    logic              advance;
    logic              done;
    logic [IDX_W-1:0]  slot_idx;
    logic              is_last;
    logic              slot_ready;
    logic [DATA_W-1:0] slot_data;
    logic              unused_low_addr;

    assign busy      = (state == ST_BUSY);
    assign req_ready = !busy;
    assign accept    = req_valid && req_ready;
    assign swap      = req_half_line && req_addr[HALF_BIT];
    assign advance   = rsp_valid && rsp_ready;
    assign done      = advance && is_last;
    assign unused_low_addr = ^req_addr[HALF_BIT-1:0];

    // Request state: busy from acceptance to the last beat's handshake.
    always_ff @(posedge clk) begin
        if (!rst_n)      state <= ST_IDLE;
        else if (accept) state <= ST_BUSY;
        else if (done)   state <= ST_IDLE;
    end

    // Line address register, captured with the request.
    always_ff @(posedge clk) begin
        if (!rst_n)      line_q <= '0;
        else if (accept) line_q <= req_addr[ADDR_W-1:OFF_W];
    end

    crl_line_store #(.DATA_W(DATA_W), .BEATS(BEATS)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (accept),
        .wr_valid (mem_valid && busy),
        .wr_data  (mem_data),
        .rd_idx   (slot_idx),
        .rd_data  (slot_data),
        .rd_ready (slot_ready)
    );

    crl_beat_sequencer #(.BEATS(BEATS)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (accept),
        .swap_in  (swap),
        .advance  (advance),
        .slot_idx (slot_idx),
        .is_last  (is_last)
    );

    assign rsp_valid = busy && slot_ready;
    assign rsp_data  = slot_data;
    assign rsp_addr  = {line_q, slot_idx, {BEAT_OFF{1'b0}}};
    assign rsp_last  = rsp_valid && is_last;

    AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (req_ready && !rsp_valid && !rsp_last)) else $error("not idle after reset"); // R1
    AST_HOLD_VALID: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> rsp_valid) else $error("valid dropped in stall"); // R7
    AST_HOLD_BEAT: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> ($stable(rsp_data) && $stable(rsp_addr) && $stable(rsp_last))) else $error("beat changed in stall"); // R7
    AST_BUSY_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n) (!req_ready && !(rsp_valid && rsp_ready && rsp_last)) |=> !req_ready) else $error("ready too early"); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_ready && rsp_last) |=> (req_ready && !rsp_valid)) else $error("no release after last"); // R2
    AST_NO_EARLY: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !rsp_valid) else $error("beat before capture"); // R9
endmodule

// File: tb/sim_crl_line_return.sv
`timescale 1ns/1ps
// Directed bench for crl_line_return: one task per scenario.
module sim_crl_line_return;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_half_line = 1'b0;
    logic        mem_valid = 1'b0;
    logic [63:0] mem_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic [63:0] rsp_data;
    logic [31:0] rsp_addr;
    logic        rsp_last;

    int n_chk = 0;
    int n_bad = 0;
    bit active = 1'b0;
    bit mem_done = 1'b0;

    always #2 clk = ~clk;

    crl_line_return u0 (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_half_line(req_half_line),
        .mem_valid(mem_valid), .mem_data(mem_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_data(rsp_data), .rsp_addr(rsp_addr), .rsp_last(rsp_last)
    );

    function automatic logic [63:0] beat_word(input int tag, input int k);
        return {16'hBEE0, tag[15:0], 24'h0, k[7:0]};
    endfunction

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // One request: drives the burst, collects eight beats, checks each one.
    task automatic run_req(input int tag, input logic [31:0] addr, input bit half,
                           input int rdy_mode, input int pause_at, input int extra,
                           input bit keep_req, input string rq);
        bit swap;
        swap = half && addr[5];
        @(posedge clk); #1;
        req_valid = 1'b1; req_addr = addr; req_half_line = half;
        @(posedge clk); #1;
        if (keep_req) req_addr = 32'hFFFF_FFE0;
        else req_valid = 1'b0;
        active = 1'b1; mem_done = 1'b0;
        fork
            begin : mem_drv
                for (int k = 0; k < 8; k++) begin
                    mem_valid = 1'b1; mem_data = beat_word(tag, k);
                    @(posedge clk); #1;
                    if (k + 1 == pause_at) begin
                        mem_valid = 1'b0;
                        for (int p = 0; p < 3; p++) begin
                            @(negedge clk);
                            if (swap) chk(rsp_valid == 1'b0, "R9", "valid before upper half", 64'(rsp_valid), 64'd0);
                            else if (p == 0) chk(rsp_valid == 1'b1, "R9", "valid after first beat", 64'(rsp_valid), 64'd1);
                            @(posedge clk); #1;
                        end
                    end
                end
                for (int e = 0; e < extra; e++) begin
                    mem_valid = 1'b1; mem_data = 64'hDEAD_DEAD_DEAD_0000 | 64'(e);
                    @(posedge clk); #1;
                end
                mem_valid = 1'b0;
                mem_done = 1'b1;
            end
            begin : rdy_drv
                int cyc;
                cyc = 0;
                while (active) begin
                    case (rdy_mode)
                        0: rsp_ready = 1'b1;
                        1: rsp_ready = (cyc % 3) != 0;
                        default: rsp_ready = mem_done;
                    endcase
                    cyc++;
                    @(posedge clk); #1;
                end
            end
            begin : collect
                int j;
                bit prev_stall;
                logic [63:0] pdata;
                logic [31:0] paddr;
                logic [2:0]  slot;
                j = 0; prev_stall = 1'b0; pdata = '0; paddr = '0;
                while (j < 8) begin
                    @(negedge clk);
                    if (keep_req) chk(req_ready == 1'b0, "R6", "ready while busy", 64'(req_ready), 64'd0);
                    if (prev_stall) begin
                        chk(rsp_valid == 1'b1, "R7", "valid held", 64'(rsp_valid), 64'd1);
                        chk(rsp_data == pdata, "R7", "data held", rsp_data, pdata);
                        chk(rsp_addr == paddr, "R7", "addr held", 64'(rsp_addr), 64'(paddr));
                    end
                    prev_stall = 1'b0;
                    if (rsp_valid) begin
                        if (rsp_ready) begin
                            slot = 3'(j) ^ (swap ? 3'd4 : 3'd0);
                            chk(rsp_data == beat_word(tag, int'(slot)), rq, "beat data", rsp_data, beat_word(tag, int'(slot)));
                            chk(rsp_addr == {addr[31:6], slot, 3'b000}, rq, "beat addr", 64'(rsp_addr), 64'({addr[31:6], slot, 3'b000}));
                            chk(rsp_last == (j == 7), "R2", "last flag", 64'(rsp_last), 64'(j == 7));
                            if (j == 7 && keep_req) req_valid = 1'b0;
                            j++;
                        end else begin
                            prev_stall = 1'b1; pdata = rsp_data; paddr = rsp_addr;
                        end
                    end
                end
                active = 1'b0;
            end
        join
        @(negedge clk);
        chk(req_ready == 1'b1, "R6", "ready after last", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R2", "no ninth beat", 64'(rsp_valid), 64'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready in reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R1", "valid in reset", 64'(rsp_valid), 64'd0);
        #1 rst_n = 1'b1;
        @(posedge clk);
        @(negedge clk);
        chk(req_ready == 1'b1, "R1", "ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0 && rsp_last == 1'b0, "R1", "valid/last after reset", 64'({rsp_valid, rsp_last}), 64'd0);
    endtask

    task automatic t_full_lines();
        run_req(1, 32'h1000_0040, 1'b0, 0, 0, 0, 1'b0, "R3");
        run_req(2, 32'h2000_0068, 1'b0, 1, 0, 0, 1'b0, "R3");
    endtask

    task automatic t_half_low();
        run_req(3, 32'h3000_0090, 1'b1, 1, 0, 0, 1'b0, "R4");
    endtask

    task automatic t_half_high();
        run_req(4, 32'h4000_00F8, 1'b1, 1, 0, 0, 1'b0, "R5");
        run_req(5, 32'h4000_0120, 1'b1, 0, 0, 0, 1'b0, "R5");
    endtask

    task automatic t_cut_through();
        run_req(6, 32'h5000_0030, 1'b1, 0, 4, 0, 1'b0, "R5");
        run_req(7, 32'h5000_0100, 1'b1, 1, 1, 0, 1'b0, "R4");
    endtask

    task automatic t_stall_and_extra();
        run_req(8, 32'h6000_0020, 1'b1, 2, 0, 2, 1'b0, "R8");
    endtask

    task automatic t_busy_ignores_req();
        run_req(9, 32'h7000_0000, 1'b1, 1, 0, 0, 1'b1, "R6");
    endtask

    task automatic t_idle_junk();
        @(posedge clk); #1;
        for (int i = 0; i < 3; i++) begin
            mem_valid = 1'b1; mem_data = 64'hBAD0_0000_0000_0000 | 64'(i);
            @(posedge clk); #1;
        end
        mem_valid = 1'b0;
        @(negedge clk);
        chk(rsp_valid == 1'b0, "R8", "idle beats offered", 64'(rsp_valid), 64'd0);
        run_req(10, 32'h8000_0070, 1'b1, 0, 0, 0, 1'b0, "R8");
    endtask

    initial begin
        t_reset();
        t_full_lines();
        t_half_low();
        t_half_high();
        t_cut_through();
        t_stall_and_extra();
        t_busy_ignores_req();
        t_idle_junk();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule